// File: doc/BRIEF.md
# Recovered Clock Switchover Sequencer

This block decides when an audio receiver's master clock may move from the free-running local clock, which comes from the crystal, to the clock recovered by the PLL. It also decides when the master clock must move back. When the PLL reports lock while input data is present, the block starts a lock-in sequence. It asserts a transition indicator on the next local word tick. It then counts a programmable number of word ticks and switches the clock-source select to the recovered clock. The indicator returns to its idle level once the receive-error flag clears.

When lock is lost, the select returns to the local clock at once and the indicator is asserted. The indicator is held for a fixed number of word ticks and then released. A loss of lock in the middle of a lock-in sequence cancels that sequence and starts the unlock sequence immediately. The lock, data and error flags are asynchronous, and each passes through a two-flop synchronizer. The word tick is a one-cycle strobe in the block's clock domain. All delays are counted in ticks and set by parameters.

Top module: `clock_switch_seq`

## Requirements
- R1: After a synchronous active-low reset, useRec is 0 and indicator sits at its idle level, which is the inverse of polSel.
- R2: The asserted level of indicator equals polSel. With polSel at 0 the indicator idles high and pulses low; with polSel at 1 it idles low and pulses high.
- R3: Lock-in starts only while both the lock and data-present flags are high. The indicator is asserted on the clock edge of a word tick. A lock flag without the data flag has no effect on either output.
- R4: useRec rises exactly MAX_DELAY >> delaySel word ticks after the indicator is asserted. Codes 0, 1, 2 and 3 give full, half, quarter and eighth of MAX_DELAY.
- R5: During lock-in, the indicator stays asserted after the switch for as long as the error flag is high. It returns to idle on the third clock edge after errIn falls.
- R6: From the locked state, a fall of lockIn drives useRec to 0 and asserts the indicator on the third clock edge, with no tick-based delay.
- R7: After a loss of lock, the indicator stays asserted for exactly UNLOCK_TICKS word ticks and useRec stays 0 throughout.
- R8: A loss of lock during the lock-in count aborts the switch. useRec never rises, the indicator stays asserted without a gap, and the unlock count of UNLOCK_TICKS ticks starts from the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| lockIn | input | 1 | PLL lock-detect flag (asynchronous) |
| dataIn | input | 1 | Input-data-present flag (asynchronous) |
| errIn | input | 1 | Receive-error flag (asynchronous) |
| tick | input | 1 | One-cycle word-rate strobe derived from the local clock |
| delaySel | input | 2 | Switch-delay code, 0 = longest |
| polSel | input | 1 | Indicator polarity; 0 = idle high, active low |
| useRec | output | 1 | Clock-source select, 1 = recovered clock |
| indicator | output | 1 | Clock transition indicator |

## Verification
A wrong sequencer state shows up within one clock edge at the ports. The select would be high while the indicator is idle, or the indicator would pulse with no change of lock. A wrong tick count can only be seen when the select rises or the indicator is released, so the bench measures both intervals in ticks for every delay code. A synchronizer of the wrong depth shifts the response to lock and error flags by a whole cycle, which the bench catches by checking the exact edge on which the response appears. Aborting a lock-in and using the wrong count limit both show up as a wrong length of the unlock pulse.

// File: rtl/csw_pkg.sv
package csw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_LOCKIN,
    ST_QUAL,
    ST_LOCKED,
    ST_UNLOCK
  } seqState_t;

  // strobes from the sequencer to the tick counter
  typedef struct packed {
    logic cntClr;    // restart the count at zero
    logic cntEn;     // count word ticks
    logic selLimit;  // 0: switch-delay limit, 1: unlock-hold limit
  } cntCtl_t;

endpackage

// File: rtl/csw_sync.sv
module csw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/csw_tick_counter.sv
module csw_tick_counter
  import csw_pkg::*;
#(
  parameter int MAX_DELAY    = 130,
  parameter int UNLOCK_TICKS = 254,
  parameter int CNT_MAX      = 254,
  parameter int CNT_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] delaySel,
  input  cntCtl_t    ctl,
  output logic       limitHit
);

  localparam logic [CNT_W-1:0] MaxDelayV = CNT_W'(MAX_DELAY);
  localparam logic [CNT_W-1:0] UnlockV   = CNT_W'(UNLOCK_TICKS);
  localparam logic [CNT_W-1:0] CntMaxV   = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  always_comb begin
    if (ctl.selLimit) target = UnlockV;
    else              target = MaxDelayV >> delaySel;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) cnt <= '0;
    else if (ctl.cntEn && tick && cnt < CntMaxV) cnt <= cnt + 1'b1;
  end

  assign limitHit = (cnt >= target);

endmodule

// File: rtl/csw_seq_ctrl.sv
module csw_seq_ctrl
  import csw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lockS,
  input  logic    dataS,
  input  logic    errS,
  input  logic    tick,
  input  logic    limitHit,
  output cntCtl_t ctl,
  output logic    useRec,
  output logic    indLow
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (lockS && dataS) nextState = ST_ARM;
      ST_ARM:    if (!lockS) nextState = ST_IDLE;
                 else if (tick) nextState = ST_LOCKIN;
      ST_LOCKIN: if (!lockS) nextState = ST_UNLOCK;
                 else if (limitHit) nextState = ST_QUAL;
      ST_QUAL:   if (!lockS) nextState = ST_UNLOCK;
                 else if (!errS) nextState = ST_LOCKED;
      ST_LOCKED: if (!lockS) nextState = ST_UNLOCK;
      ST_UNLOCK: if (limitHit) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.cntClr   = (nextState != state);
    ctl.cntEn    = (state == ST_LOCKIN) || (state == ST_UNLOCK);
    ctl.selLimit = (state == ST_UNLOCK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      useRec <= 1'b0;
      indLow <= 1'b0;
    end else begin
      state  <= nextState;
      useRec <= (nextState == ST_QUAL) || (nextState == ST_LOCKED);
      indLow <= (nextState == ST_LOCKIN) || (nextState == ST_QUAL) ||
                (nextState == ST_UNLOCK);
    end
  end

endmodule

// File: rtl/clock_switch_seq.sv
module clock_switch_seq
  import csw_pkg::*;
#(
  parameter int MAX_DELAY    = 130,
  parameter int UNLOCK_TICKS = 254
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic       dataIn,
  input  logic       errIn,
  input  logic       tick,
  input  logic [1:0] delaySel,
  input  logic       polSel,
  output logic       useRec,
  output logic       indicator
);

  localparam int CNT_MAX = (MAX_DELAY > UNLOCK_TICKS) ? MAX_DELAY : UNLOCK_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic    lockS, dataS, errS;
  logic    limitHit;
  logic    indLow;
  cntCtl_t ctl;

  csw_sync #(.W(3)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({lockIn, dataIn, errIn}),
    .dout({lockS, dataS, errS})
  );

  csw_seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lockS   (lockS),
    .dataS   (dataS),
    .errS    (errS),
    .tick    (tick),
    .limitHit(limitHit),
    .ctl     (ctl),
    .useRec  (useRec),
    .indLow  (indLow)
  );

  csw_tick_counter #(
    .MAX_DELAY   (MAX_DELAY),
    .UNLOCK_TICKS(UNLOCK_TICKS),
    .CNT_MAX     (CNT_MAX),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .delaySel(delaySel),
    .ctl     (ctl),
    .limitHit(limitHit)
  );

  assign indicator = ~(indLow ^ polSel);

endmodule

// File: rtl/csw_checker.sv
module csw_checker (
  input logic clk,
  input logic rstN,
  input logic lockS,
  input logic useRec,
  input logic indicator,
  input logic polSel
);

  logic active;
  assign active = (indicator == polSel);

  // R4
  switch_while_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(useRec) |-> active);

  // R3
  switch_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(useRec) |-> $past(lockS));

  // R7
  return_marked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(useRec) |-> active);

  // R6
  unlock_immediate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lockS) && useRec) |=> (!useRec && active));

  // R8
  no_switch_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockS |=> !useRec);

endmodule

bind clock_switch_seq csw_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lockS    (lockS),
  .useRec   (useRec),
  .indicator(indicator),
  .polSel   (polSel)
);

// File: tb/clock_switch_seq_tb.sv
module clock_switch_seq_tb;

  localparam int MAXD = 16;
  localparam int UNL  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockIn = 1'b0, dataIn = 1'b0, errIn = 1'b1, tick = 1'b0;
  logic [1:0] delaySel = 2'd0;
  logic polSel = 1'b0;
  logic useRec, indicator;

  int errCnt = 0;
  int chkCnt = 0;
  int tickCount = 0;
  int div = 0;
  logic tickPrev = 1'b0;

  always #10 clk = ~clk;

  clock_switch_seq #(.MAX_DELAY(MAXD), .UNLOCK_TICKS(UNL)) u_dut (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .dataIn(dataIn), .errIn(errIn),
    .tick(tick), .delaySel(delaySel), .polSel(polSel),
    .useRec(useRec), .indicator(indicator)
  );

  always @(negedge clk) begin
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  always @(posedge clk) begin
    tickPrev <= tick;
    if (tick) tickCount <= tickCount + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isActive();
    return indicator == polSel;
  endfunction

  task automatic waitActive(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (isActive()) begin ok = 1'b1; break; end
    end
  endtask

  task automatic runCase(input bit pol, input int code);
    bit ok, bad;
    int tA, tU;
    polSel = pol; delaySel = 2'(code);
    lockIn = 0; dataIn = 0; errIn = 1; rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(useRec == 0 && indicator == !pol, "R1 reset levels", {useRec, indicator}, {1'b0, !pol});

    // R3: lock without data has no effect
    lockIn = 1;
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (isActive() || useRec) bad = 1;
    end
    chk(!bad, "R3 lock without data ignored", bad, 0);

    dataIn = 1;
    waitActive(ok);
    chk(ok, "R3 lock-in indicator asserted", ok, 1);
    chk(tickPrev == 1, "R3 assertion on tick edge", tickPrev, 1);
    // R2
    chk(indicator == pol, "R2 active level", indicator, pol);
    tA = tickCount;

    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (useRec) begin ok = 1; break; end
    end
    // R4
    chk(ok && (tickCount - tA) == (MAXD >> code), "R4 switch delay ticks", tickCount - tA, MAXD >> code);
    chk(isActive(), "R5 held after switch with error", indicator, pol);
    repeat (10) @(negedge clk);
    chk(isActive(), "R5 held while error high", indicator, pol);

    errIn = 0;
    repeat (2) @(negedge clk);
    chk(isActive(), "R5 no release before third edge", indicator, pol);
    @(negedge clk);
    chk(!isActive() && useRec, "R5 release on third edge", indicator, !pol);

    // R6
    lockIn = 0; errIn = 1;
    repeat (2) @(negedge clk);
    chk(useRec == 1, "R6 select before third edge", useRec, 1);
    @(negedge clk);
    chk(useRec == 0 && isActive(), "R6 immediate return to local", {useRec, indicator}, {1'b0, pol});
    tU = tickCount;
    bad = 0;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (useRec) bad = 1;
      if (!isActive()) begin ok = 1; break; end
    end
    // R7
    chk(ok && (tickCount - tU) == UNL, "R7 unlock hold ticks", tickCount - tU, UNL);
    chk(!bad, "R7 select stays local", bad, 0);

    // R8: abort during lock-in count
    lockIn = 1;
    waitActive(ok);
    chk(ok, "R8 lock-in restarted", ok, 1);
    tA = tickCount;
    while (tickCount < tA + 1) @(negedge clk);
    lockIn = 0;
    bad = 0;
    repeat (3) begin
      @(negedge clk);
      if (useRec || !isActive()) bad = 1;
    end
    tU = tickCount;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (useRec) bad = 1;
      if (!isActive()) begin ok = 1; break; end
    end
    chk(!bad, "R8 no switch and no gap on abort", bad, 0);
    chk(ok && (tickCount - tU) == UNL, "R8 unlock hold after abort", tickCount - tU, UNL);
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 4; c++)
        runCase(p[0], c);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++;
    errCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule